// File: doc/BRIEF.md
# Perfect Access Pattern Sequencer

This block drives the schedule of a parallel machine whose memory modules stand for the points of a finite projective plane and whose processors stand for its lines. Point k is the k-th power of a field generator, so advancing a point by one step is an increment of its index modulo n, where n = s*s + s + 1. Line l is the set {d + l mod n : d in D}, with D a difference set of s + 1 residues. Under the same increment, every line maps onto another line.

After a start command the sequencer takes a seed line and walks every ordered pair of distinct points on it. Each pair seeds one perfect pattern: n triples (point a, point b, line), each one the previous triple shifted by one index. Within a pattern every memory module is read once as first operand and once as second operand, and every processor is busy exactly once. This holds with no conflicts. Across the complete sequence of s*(s+1) patterns every point-to-line link carries the same amount of traffic. One triple is offered per cycle under a valid/ready handshake. Markers flag the first and last triple of each pattern and the final triple of the sequence.

Top module: `perfect_sched_seq`

## Requirements
- R1: While reset is high, and in the cycle after it is released, out_valid, busy and all three marker outputs are 0.
- R2: A start pulse seen at a clock edge while busy is 0 latches seed_line. From the cycle after that edge, out_valid and busy are 1 and the first triple is presented. The value on seed_line after that edge has no effect.
- R3: Pattern seeds are taken from position indices (i, j) of the difference set, stored in the order D = {0, 1, 3}. The first index is the outer loop and the second index is the inner loop, and i == j is skipped. The seed pair is a = (D[i] + L) mod n and b = (D[j] + L) mod n, where L is the seed line. With s = 2 this gives 6 patterns and 42 triples.
- R4: Triple k of a pattern (k = 0..n-1) is pa = (a+k) mod n, pb = (b+k) mod n and line_id = (L+k) mod n.
- R5: Within one pattern, pa takes every value 0..n-1 exactly once, and so do pb and line_id. pa never equals pb.
- R6: first_of_pattern is 1 exactly at k = 0 and last_of_pattern is 1 exactly at k = n-1. last_of_sequence is 1 only on triple n-1 of the final pattern.
- R7: While out_valid is 1 and out_ready is 0, all outputs keep their values.
- R8: A start pulse while busy is 1 is ignored. The sequence in progress continues unchanged.
- R9: In the cycle after the last_of_sequence triple is accepted, out_valid and busy are 0, and a new start is then accepted.
- R10: pa and pb always lie on line_id. Over one full sequence, each link (point p, line l) with p on l is used exactly 2*s times, counting pa and pb uses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sequence (taken only when idle) |
| seed_line | input | IW | Index of the seed line, below n |
| out_ready | input | 1 | Consumer accepts the current triple |
| out_valid | output | 1 | A triple is presented |
| pa | output | IW | First-operand point (memory module) |
| pb | output | IW | Second-operand point (memory module) |
| line_id | output | IW | Line (processor) joining pa and pb |
| first_of_pattern | output | 1 | Triple k = 0 of a pattern |
| last_of_pattern | output | 1 | Triple k = n-1 of a pattern |
| last_of_sequence | output | 1 | Final triple of the final pattern |
| busy | output | 1 | A sequence is in progress |

## Verification
The internal state consists of the latched seed, the pair indices and the shift count. A corrupted seed shows at once as a wrong line_id on the very first triple after start. A slipped pair walk shows as a wrong pa or pb at the next first_of_pattern triple, so within at most n accepted triples. A shift count that is off by one breaks the per-pattern permutation and the marker positions within the same pattern. The link-usage tally at the end of each sequence catches a pair that is skipped or repeated, even when each pattern on its own looks plausible.

// File: rtl/psq_pkg.sv
package psq_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    // number of points (and of lines) of a projective plane of the given order
    function automatic int unsigned plane_points(input int unsigned ord);
        return ord * ord + ord + 1;
    endfunction

    // number of points on one line
    function automatic int unsigned line_points(input int unsigned ord);
        return ord + 1;
    endfunction

    // bits needed to hold an index below n
    function automatic int unsigned idx_bits(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/psq_mod_add.sv
module psq_mod_add #(
    parameter int unsigned N  = 7,
    parameter int unsigned IW = 3
) (
    input  logic [IW-1:0] a,
    input  logic [IW-1:0] b,
    output logic [IW-1:0] sum
);
    localparam logic [IW:0] MODV = (IW+1)'(N);

    logic [IW:0] raw;

    always_comb begin
        raw = {1'b0, a} + {1'b0, b};
        if (raw >= MODV) raw = raw - MODV;
        sum = raw[IW-1:0];
    end
endmodule

// File: rtl/psq_pair_walk.sv
module psq_pair_walk #(
    parameter int unsigned K  = 3,
    parameter int unsigned KW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          step,
    output logic [KW-1:0] idx_i,
    output logic [KW-1:0] idx_j,
    output logic          last_pair
);
    localparam logic [KW:0]   KLIM  = (KW+1)'(K);
    localparam logic [KW-1:0] LAST_I = KW'(K - 1);
    localparam logic [KW-1:0] LAST_J = KW'(K - 2);

    logic [KW-1:0] nxt_i, nxt_j;
    logic [KW:0]   cand;

    always_comb begin
        cand = {1'b0, idx_j} + 1'b1;
        if (cand == {1'b0, idx_i}) cand = cand + 1'b1;
        if (cand >= KLIM) begin
            nxt_i = idx_i + 1'b1;
            nxt_j = '0;
        end else begin
            nxt_i = idx_i;
            nxt_j = cand[KW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_i <= '0;
            idx_j <= KW'(1);
        end else if (load) begin
            idx_i <= '0;
            idx_j <= KW'(1);
        end else if (step) begin
            idx_i <= nxt_i;
            idx_j <= nxt_j;
        end
    end

    assign last_pair = (idx_i == LAST_I) && (idx_j == LAST_J);
endmodule

// File: rtl/psq_shift_count.sv
module psq_shift_count #(
    parameter int unsigned N  = 7,
    parameter int unsigned IW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          step,
    output logic [IW-1:0] k,
    output logic          at_first,
    output logic          at_last
);
    localparam logic [IW-1:0] KMAX = IW'(N - 1);

    always_ff @(posedge clk) begin
        if (rst || load) begin
            k <= '0;
        end else if (step) begin
            k <= (k == KMAX) ? '0 : k + 1'b1;
        end
    end

    assign at_first = (k == '0);
    assign at_last  = (k == KMAX);
endmodule

// File: rtl/perfect_sched_seq.sv
module perfect_sched_seq
    import psq_pkg::*;
#(
    parameter int unsigned ORDER = 2,
    parameter int unsigned DSET [ORDER+1] = '{0, 1, 3},
    localparam int unsigned N  = plane_points(ORDER),
    localparam int unsigned IW = idx_bits(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [IW-1:0] seed_line,
    input  logic          out_ready,
    output logic          out_valid,
    output logic [IW-1:0] pa,
    output logic [IW-1:0] pb,
    output logic [IW-1:0] line_id,
    output logic          first_of_pattern,
    output logic          last_of_pattern,
    output logic          last_of_sequence,
    output logic          busy
);
    localparam int unsigned K     = line_points(ORDER);
    localparam int unsigned KW    = idx_bits(K);
    localparam int unsigned LANES = 3;

    typedef struct packed {
        logic [IW-1:0] a;
        logic [IW-1:0] b;
        logic [IW-1:0] l;
    } triple_t;

    run_state_e    state_q;
    logic [IW-1:0] seed_q;
    logic [KW-1:0] idx_i, idx_j;
    logic          last_pair;
    logic [IW-1:0] k;
    logic          k_first, k_last;
    logic          accept, fire, seq_end;

    logic [IW-1:0] dtab      [K];
    logic [IW-1:0] pick      [2];
    logic [IW-1:0] lane_base [LANES];
    logic [IW-1:0] lane_out  [LANES];
    triple_t       cur;

    // difference-set table, reduced modulo n
    for (genvar g = 0; g < K; g++) begin : g_dtab
        assign dtab[g] = IW'(DSET[g] % N);
    end

    assign accept  = (state_q == ST_IDLE) && start;
    assign fire    = (state_q == ST_RUN) && out_ready;
    assign seq_end = fire && k_last && last_pair;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            seed_q  <= '0;
        end else begin
            if (accept) begin
                state_q <= ST_RUN;
                seed_q  <= seed_line;
            end else if (seq_end) begin
                state_q <= ST_IDLE;
            end
        end
    end

    psq_pair_walk #(.K(K), .KW(KW)) u_pairs (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .step      (fire && k_last),
        .idx_i     (idx_i),
        .idx_j     (idx_j),
        .last_pair (last_pair)
    );

    psq_shift_count #(.N(N), .IW(IW)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .step     (fire),
        .k        (k),
        .at_first (k_first),
        .at_last  (k_last)
    );

    // seed pair on the seed line: difference-set element plus line offset
    assign pick[0] = dtab[idx_i];
    assign pick[1] = dtab[idx_j];

    for (genvar s = 0; s < 2; s++) begin : g_seed
        psq_mod_add #(.N(N), .IW(IW)) u_seed_add (
            .a   (pick[s]),
            .b   (seed_q),
            .sum (lane_base[s])
        );
    end
    assign lane_base[2] = seed_q;

    // cyclic shift of every lane by k
    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        psq_mod_add #(.N(N), .IW(IW)) u_shift_add (
            .a   (lane_base[ln]),
            .b   (k),
            .sum (lane_out[ln])
        );
    end

    assign cur = '{a: lane_out[0], b: lane_out[1], l: lane_out[2]};

    assign out_valid        = (state_q == ST_RUN);
    assign busy             = (state_q == ST_RUN);
    assign pa               = cur.a;
    assign pb               = cur.b;
    assign line_id          = cur.l;
    assign first_of_pattern = out_valid && k_first;
    assign last_of_pattern  = out_valid && k_last;
    assign last_of_sequence = out_valid && k_last && last_pair;
endmodule

// File: rtl/psq_seq_chk.sv
module psq_seq_chk
    import psq_pkg::*;
#(
    parameter int unsigned ORDER = 2,
    parameter int unsigned DSET [ORDER+1] = '{0, 1, 3},
    localparam int unsigned N  = plane_points(ORDER),
    localparam int unsigned IW = idx_bits(N)
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic [IW-1:0] seed_line,
    input logic          out_ready,
    input logic          out_valid,
    input logic [IW-1:0] pa,
    input logic [IW-1:0] pb,
    input logic [IW-1:0] line_id,
    input logic          first_of_pattern,
    input logic          last_of_pattern,
    input logic          last_of_sequence,
    input logic          busy
);
    function automatic logic on_line(input logic [IW-1:0] p, input logic [IW-1:0] l);
        int unsigned diff;
        logic        hit;
        diff = (int'(p) + N - int'(l)) % N;
        hit  = 1'b0;
        for (int unsigned q = 0; q < ORDER + 1; q++) begin
            if (DSET[q] % N == diff) hit = 1'b1;
        end
        return hit;
    endfunction

    logic fire;
    assign fire = out_valid && out_ready;

    a_r2_first_triple: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> (out_valid && first_of_pattern && line_id == $past(seed_line)));

    a_r4_line_shift: assert property (@(posedge clk) disable iff (rst)
        (fire && !last_of_pattern) |=> (int'(line_id) == (int'($past(line_id)) + 1) % N));

    a_r5_distinct: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (pa != pb));

    a_r6_next_pattern: assert property (@(posedge clk) disable iff (rst)
        (fire && last_of_pattern && !last_of_sequence) |=> (out_valid && first_of_pattern));

    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(pa) && $stable(pb) && $stable(line_id)
            && $stable(first_of_pattern) && $stable(last_of_pattern) && $stable(last_of_sequence)));

    a_r8_restart_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy && !fire && start) |=> (busy && $stable(line_id) && $stable(pa)));

    a_r9_done: assert property (@(posedge clk) disable iff (rst)
        (fire && last_of_sequence) |=> (!out_valid && !busy));

    a_r10_on_line: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (on_line(pa, line_id) && on_line(pb, line_id)));

    a_r1_quiet_idle: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (!first_of_pattern && !last_of_pattern && !last_of_sequence));
endmodule

bind perfect_sched_seq psq_seq_chk #(.ORDER(ORDER), .DSET(DSET)) u_chk (.*);

// File: tb/sim_perfect_sched_seq.sv
module sim_perfect_sched_seq;
    localparam int NP = 7;
    localparam int NPAT = 6;
    localparam int NTRI = NP * NPAT;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [2:0] seed_line = '0;
    logic       out_ready = 1'b0;
    logic       out_valid;
    logic [2:0] pa, pb, line_id;
    logic       first_of_pattern, last_of_pattern, last_of_sequence, busy;

    int total = 0;
    int bad = 0;
    int dset [3] = '{0, 1, 3};
    int pi_l [NPAT];
    int pj_l [NPAT];
    int links [NP][NP];
    logic [7:0] lfsr = 8'hA5;

    always #4 clk = ~clk;

    perfect_sched_seq u0 (
        .clk(clk), .rst(rst), .start(start), .seed_line(seed_line),
        .out_ready(out_ready), .out_valid(out_valid), .pa(pa), .pb(pb),
        .line_id(line_id), .first_of_pattern(first_of_pattern),
        .last_of_pattern(last_of_pattern), .last_of_sequence(last_of_sequence),
        .busy(busy)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit pt_on(input int p, input int l);
        bit hit = 0;
        for (int q = 0; q < 3; q++) if ((p - l + NP) % NP == dset[q]) hit = 1;
        return hit;
    endfunction

    task automatic run_seq(input int seed, input int mode, input bit inject);
        int idx = 0;
        int guard = 0;
        bit held = 0;
        int h_pa = 0, h_pb = 0, h_ln = 0, h_fl = 0;
        int ma = 0, mb = 0, ml = 0;
        bit rdy;
        string rq;
        for (int p = 0; p < NP; p++) for (int l = 0; l < NP; l++) links[p][l] = 0;
        @(negedge clk);
        start = 1'b1;
        seed_line = 3'(seed);
        @(negedge clk);
        start = 1'b0;
        seed_line = 3'((seed + 1) % NP);
        chk("R2", "valid after start", int'(out_valid), 1);
        chk("R2", "first line", int'(line_id), seed);
        while (idx < NTRI && guard < 2000) begin
            if (held) begin
                chk("R7", "hold pa", int'(pa), h_pa);
                chk("R7", "hold pb", int'(pb), h_pb);
                chk("R7", "hold line", int'(line_id), h_ln);
                chk("R7", "hold flags", int'({first_of_pattern, last_of_pattern, last_of_sequence}), h_fl);
            end
            chk("R2", "busy in run", int'(busy && out_valid), 1);
            case (mode)
                0: rdy = 1'b1;
                1: rdy = (guard % 3) != 2;
                2: begin
                    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                    rdy = lfsr[0];
                end
                default: rdy = (guard % 8) >= 5;
            endcase
            out_ready = rdy;
            if (inject && idx == 10) begin
                start = 1'b1;
                seed_line = 3'((seed + 3) % NP);
            end else begin
                start = 1'b0;
            end
            if (rdy) begin
                int pt = idx / NP;
                int k = idx % NP;
                int ea = (dset[pi_l[pt]] + seed + k) % NP;
                int eb = (dset[pj_l[pt]] + seed + k) % NP;
                int el = (seed + k) % NP;
                rq = (inject && idx > 10) ? "R8" : ((k == 0) ? "R3" : "R4");
                chk(rq, "pa", int'(pa), ea);
                chk(rq, "pb", int'(pb), eb);
                chk(rq, "line", int'(line_id), el);
                chk("R6", "first", int'(first_of_pattern), int'(k == 0));
                chk("R6", "last_pat", int'(last_of_pattern), int'(k == NP - 1));
                chk("R6", "last_seq", int'(last_of_sequence), int'(idx == NTRI - 1));
                chk("R10", "pa on line", int'(pt_on(int'(pa), int'(line_id))), 1);
                chk("R10", "pb on line", int'(pt_on(int'(pb), int'(line_id))), 1);
                links[pa][line_id]++;
                links[pb][line_id]++;
                if (k == 0) begin ma = 0; mb = 0; ml = 0; end
                ma |= 1 << pa;
                mb |= 1 << pb;
                ml |= 1 << line_id;
                if (k == NP - 1) begin
                    chk("R5", "pa perm", ma, 7'h7F);
                    chk("R5", "pb perm", mb, 7'h7F);
                    chk("R5", "line perm", ml, 7'h7F);
                end
                idx++;
                held = 0;
            end else begin
                held = 1;
                h_pa = int'(pa);
                h_pb = int'(pb);
                h_ln = int'(line_id);
                h_fl = int'({first_of_pattern, last_of_pattern, last_of_sequence});
            end
            @(negedge clk);
            guard++;
        end
        start = 1'b0;
        out_ready = 1'b0;
        chk("R9", "triples done", idx, NTRI);
        chk("R9", "valid drop", int'(out_valid), 0);
        chk("R9", "busy drop", int'(busy), 0);
        for (int p = 0; p < NP; p++)
            for (int l = 0; l < NP; l++)
                chk("R10", "link use", links[p][l], pt_on(p, l) ? 4 : 0);
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n = 0;
        for (int i = 0; i < 3; i++)
            for (int j = 0; j < 3; j++)
                if (i != j) begin
                    pi_l[n] = i;
                    pj_l[n] = j;
                    n++;
                end
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "valid in reset", int'(out_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "valid after reset", int'(out_valid), 0);
        chk("R1", "busy after reset", int'(busy), 0);
        chk("R1", "flags after reset",
            int'({first_of_pattern, last_of_pattern, last_of_sequence}), 0);
        for (int s = 0; s < NP; s++) run_seq(s, s % 4, s == 2);
        run_seq(5, 3, 1'b1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule